// File: doc/BRIEF.md
# Queued Read Request Engine

This block sits between a requester and a memory controller's native command port. The requester offers read requests on a valid/ready stream, each carrying an address and a tag. The requests wait in a request FIFO. A single-access engine takes them one at a time, presents a read command to the memory port and waits for the read data. It then pushes a response word, holding the tag and the data, into a response FIFO. The requester drains that FIFO through a second valid/ready stream.

Every register in the block runs on the user clock that the memory controller supplies. No command is issued until the controller reports that calibration is done. A command that has been presented is held until the controller signals that it can take it. Requests can still be queued before calibration is done, but they stay in the request FIFO.

Back-pressure rules. On the request stream, a transfer happens on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` falls when the request FIFO is full. An offer made while it is low is not stored. On the response stream, a word leaves on an edge where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, the word on offer stays unchanged. When the response FIFO is full, the engine waits with its finished response and does not drop it.

Top module: `mreq_engine`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `req_ready` is 1 and `rsp_valid`, `mem_cmd_en` and `acc_done` are 0.
- R2: A request is stored on each edge with `req_valid && req_ready`. Once REQ_DEPTH requests are held, `req_ready` is 0, and an offer made while `req_ready` is 0 is never stored and never answered.
- R3: `mem_cmd_en` is never high while `mem_calib_done` is low. Queued requests wait until calibration is done.
- R4: While calibration stays done, `mem_cmd_en` stays high with a stable `mem_cmd_addr` until an edge where `mem_cmd_rdy` is high. It is low in the next cycle. Each accepted request produces exactly one accepted command.
- R5: Commands are issued in the order the requests were accepted, and each carries the address of its request.
- R6: Each response word carries the tag of its request unchanged, on `rsp_tag`, and the data seen on `mem_rd_data` when `mem_rd_valid` was high, on `rsp_data`. Responses leave in request order.
- R7: `acc_done` is high for exactly one cycle per response written into the response FIFO. It is never high in two consecutive cycles.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_tag` and `rsp_data` hold. When the response FIFO is full, the engine stalls and drops no response.
- R9: At most one access is outstanding. No new command is presented until the previous access's response has been written.
- R10: When the engine is idle, calibration is done and the request FIFO is empty, `mem_cmd_en` rises in the third cycle after the edge on which a request is accepted.

Default parameter values: ADDR_W 16, TAG_W 4, DATA_W 32, REQ_DEPTH 4, RSP_DEPTH 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory user clock; all state runs on it |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request FIFO has room |
| req_addr | input | ADDR_W | Read address of the request |
| req_tag | input | TAG_W | Requester tag, returned with the response |
| mem_calib_done | input | 1 | Controller calibration finished |
| mem_cmd_rdy | input | 1 | Controller can take a command this cycle |
| mem_cmd_en | output | 1 | Read command presented |
| mem_cmd_addr | output | ADDR_W | Address of the presented command |
| mem_rd_valid | input | 1 | Read data valid for one cycle |
| mem_rd_data | input | DATA_W | Read data |
| rsp_valid | output | 1 | Response word available |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_tag | output | TAG_W | Tag of the response |
| rsp_data | output | DATA_W | Data of the response |
| acc_done | output | 1 | One-cycle strobe as a response enters the response FIFO |

## Verification
The properties assume that the memory side follows its protocol. `mem_rd_valid` arrives as a single pulse only after a command has been accepted, and `mem_cmd_rdy` is only raised while calibration is done. The behavioural memory stub in the bench keeps to this. It returns one read pulse after a random delay of 1 to 4 cycles for each accepted command, and it raises ready at random only while calibration is high. The requester and consumer models drive their streams with random rates and respect the valid/ready rules. Calibration is dropped and restored at random points during a run to exercise the hold-off.

// File: rtl/mreq_pkg.sv
package mreq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_PUSH  = 3'd4
  } mreq_state_e;
endpackage

// File: rtl/mreq_fifo.sv
module mreq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_valid && out_ready;
  assign out_data  = store[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mreq_ctrl.sv
module mreq_ctrl
  import mreq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rq_avail,
  input  logic [ADDR_W-1:0] rq_addr,
  input  logic [TAG_W-1:0]  rq_tag,
  output logic              rq_pop,
  input  logic              calib_done,
  input  logic              cmd_rdy,
  output logic              cmd_en,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rs_room,
  output logic              rs_push,
  output logic [TAG_W-1:0]  rs_tag,
  output logic [DATA_W-1:0] rs_data
);
  mreq_state_e       st, nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q;

  assign rq_pop   = (st == ST_IDLE) && rq_avail && calib_done;
  assign cmd_en   = (st == ST_ISSUE) && calib_done;
  assign rs_push  = (st == ST_PUSH) && rs_room;
  assign cmd_addr = addr_q;
  assign rs_tag   = tag_q;
  assign rs_data  = data_q;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:  if (rq_pop) nxt = ST_FETCH;
      ST_FETCH: nxt = ST_ISSUE;
      ST_ISSUE: if (cmd_en && cmd_rdy) nxt = ST_WAIT;
      ST_WAIT:  if (rd_valid) nxt = ST_PUSH;
      ST_PUSH:  if (rs_room) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      st <= nxt;
      if (rq_pop) begin
        addr_q <= rq_addr;
        tag_q  <= rq_tag;
      end
      if ((st == ST_WAIT) && rd_valid) data_q <= rd_data;
    end
  end
endmodule

// File: rtl/mreq_engine.sv
module mreq_engine #(
  parameter int ADDR_W    = 16,
  parameter int TAG_W     = 4,
  parameter int DATA_W    = 32,
  parameter int REQ_DEPTH = 4,
  parameter int RSP_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              mem_calib_done,
  input  logic              mem_cmd_rdy,
  output logic              mem_cmd_en,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data,
  output logic              acc_done
);
  localparam int RQW = TAG_W + ADDR_W;
  localparam int RSW = TAG_W + DATA_W;

  logic              rq_avail, rq_pop, rs_room;
  logic [RQW-1:0]    rq_word;
  logic [TAG_W-1:0]  eng_tag;
  logic [DATA_W-1:0] eng_data;
  logic [RSW-1:0]    rs_word;

  mreq_fifo #(.W(RQW), .DEPTH(REQ_DEPTH)) u_req_q (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data({req_tag, req_addr}),
    .out_valid(rq_avail), .out_ready(rq_pop), .out_data(rq_word)
  );

  mreq_ctrl #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rq_avail(rq_avail), .rq_addr(rq_word[ADDR_W-1:0]), .rq_tag(rq_word[RQW-1:ADDR_W]),
    .rq_pop(rq_pop),
    .calib_done(mem_calib_done), .cmd_rdy(mem_cmd_rdy),
    .cmd_en(mem_cmd_en), .cmd_addr(mem_cmd_addr),
    .rd_valid(mem_rd_valid), .rd_data(mem_rd_data),
    .rs_room(rs_room), .rs_push(acc_done), .rs_tag(eng_tag), .rs_data(eng_data)
  );

  mreq_fifo #(.W(RSW), .DEPTH(RSP_DEPTH)) u_rsp_q (
    .clk(clk), .rst_n(rst_n),
    .in_valid(acc_done), .in_ready(rs_room), .in_data({eng_tag, eng_data}),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(rs_word)
  );

  assign rsp_tag  = rs_word[RSW-1:DATA_W];
  assign rsp_data = rs_word[DATA_W-1:0];
endmodule

// File: rtl/mreq_engine_chk.sv
module mreq_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_calib_done,
  input logic              mem_cmd_rdy,
  input logic              mem_cmd_en,
  input logic [ADDR_W-1:0] mem_cmd_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [TAG_W-1:0]  rsp_tag,
  input logic [DATA_W-1:0] rsp_data,
  input logic              acc_done
);
  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (mem_cmd_en && mem_cmd_rdy) outstanding <= 1'b1;
    else if (acc_done) outstanding <= 1'b0;
  end

  p_no_cmd_uncal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_en |-> mem_calib_done);

  p_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_en && !mem_cmd_rdy) |=>
      (!mem_calib_done || (mem_cmd_en && $stable(mem_cmd_addr))));

  p_en_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_en && mem_cmd_rdy) |=> !mem_cmd_en);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_done);

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_tag) && $stable(rsp_data)));

  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_en |-> !outstanding);
endmodule

bind mreq_engine mreq_engine_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_calib_done(mem_calib_done), .mem_cmd_rdy(mem_cmd_rdy),
  .mem_cmd_en(mem_cmd_en), .mem_cmd_addr(mem_cmd_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_data(rsp_data), .acc_done(acc_done)
);

// File: tb/test_mreq_engine.sv
`timescale 1ns/1ps
module test_mreq_engine;
  localparam int AW = 16, TW = 4, DW = 32, RQD = 4, RSD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, mem_calib_done = 1'b0, mem_cmd_rdy = 1'b0;
  logic mem_rd_valid = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_tag = '0;
  logic [DW-1:0] mem_rd_data = '0;
  logic req_ready, mem_cmd_en, rsp_valid, acc_done;
  logic [AW-1:0] mem_cmd_addr;
  logic [TW-1:0] rsp_tag;
  logic [DW-1:0] rsp_data;

  always #4 clk = ~clk;

  mreq_engine #(.ADDR_W(AW), .TAG_W(TW), .DATA_W(DW), .REQ_DEPTH(RQD), .RSP_DEPTH(RSD)) i_mreq_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_tag(req_tag), .mem_calib_done(mem_calib_done),
    .mem_cmd_rdy(mem_cmd_rdy), .mem_cmd_en(mem_cmd_en), .mem_cmd_addr(mem_cmd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_data(rsp_data), .acc_done(acc_done)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  int req_budget = 0, req_rate = 100, rsp_rate = 100, rdy_force = 0;
  int accepted = 0, cmd_cnt = 0, done_cnt = 0, rsp_cnt = 0;
  int viol_uncal = 0, viol_hold = 0, viol_done2 = 0, viol_outst = 0;
  int last_acc_cyc = 0, first_en_cyc = 0;
  logic [AW-1:0] exp_cmd [$];
  logic [TW+AW-1:0] exp_rsp [$];
  logic mem_busy = 1'b0, prev_en = 1'b0, prev_accept = 1'b0, prev_done = 1'b0;
  logic [AW-1:0] prev_addr = '0, mem_addr = '0;
  int mem_lat = 0;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // requester model
  always @(negedge clk) begin
    if (rst_n && req_budget > 0 && ($urandom % 100) < req_rate) begin
      req_valid = 1'b1;
      req_addr  = AW'($urandom);
      req_tag   = TW'($urandom);
      if (req_ready) begin
        exp_cmd.push_back(req_addr);
        exp_rsp.push_back({req_tag, req_addr});
        accepted++;
        req_budget--;
        last_acc_cyc = cyc;
      end
    end else begin
      req_valid = 1'b0;
    end
  end

  // memory stub and protocol monitors
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_cmd_en && !mem_calib_done) viol_uncal++;
      if (prev_en && !prev_accept && mem_calib_done &&
          (!mem_cmd_en || mem_cmd_addr != prev_addr)) viol_hold++;
      if (prev_accept && mem_cmd_en) viol_hold++;
      if (mem_cmd_en && !prev_en) first_en_cyc = cyc;
      if (mem_cmd_en && (mem_busy || cmd_cnt != done_cnt)) viol_outst++;
      if (acc_done && prev_done) viol_done2++;
      if (acc_done) done_cnt++;
      prev_done = acc_done;
      mem_rd_valid = 1'b0;
      if (mem_busy) begin
        mem_lat--;
        if (mem_lat == 0) begin
          mem_rd_valid = 1'b1;
          mem_rd_data  = mem_word(mem_addr);
          mem_busy     = 1'b0;
        end
      end
      mem_cmd_rdy = mem_calib_done && (rdy_force != 0 || ($urandom % 3) != 0);
      prev_en     = mem_cmd_en;
      prev_addr   = mem_cmd_addr;
      prev_accept = mem_cmd_en && mem_cmd_rdy;
      if (mem_cmd_en && mem_cmd_rdy) begin
        cmd_cnt++;
        if (exp_cmd.size() == 0) check("R5 extra command", 1'b0, mem_cmd_addr, 0);
        else begin
          check("R5 command address", mem_cmd_addr == exp_cmd[0], mem_cmd_addr, exp_cmd[0]);
          void'(exp_cmd.pop_front());
        end
        mem_addr = mem_cmd_addr;
        mem_busy = 1'b1;
        mem_lat  = 1 + int'($urandom % 4);
      end
    end
  end

  // response consumer
  always @(negedge clk) begin
    if (rst_n) begin
      rsp_ready = (($urandom % 100) < rsp_rate);
      if (rsp_valid && rsp_ready) begin
        rsp_cnt++;
        if (exp_rsp.size() == 0) check("R6 extra response", 1'b0, rsp_tag, 0);
        else begin
          check("R6 response tag", rsp_tag == exp_rsp[0][TW+AW-1:AW], rsp_tag, exp_rsp[0][TW+AW-1:AW]);
          check("R6 response data", rsp_data == mem_word(exp_rsp[0][AW-1:0]),
                rsp_data, mem_word(exp_rsp[0][AW-1:0]));
          void'(exp_rsp.pop_front());
        end
      end
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drain;
    int lim = 0;
    while ((exp_rsp.size() != 0 || req_budget != 0) && lim < 20000) begin
      @(posedge clk);
      lim++;
    end
    #2;
    check("R8 all responses delivered", exp_rsp.size() == 0, exp_rsp.size(), 0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog expired", 1'b0, cyc, 0);
    finish_run();
  end

  initial begin
    int base;
    void'($urandom(32'd1234));
    wait_cycles(3);
    check("R1 req_ready in reset", req_ready == 1'b1, req_ready, 1);
    check("R1 outputs quiet in reset", {rsp_valid, mem_cmd_en, acc_done} == 3'b000,
          {rsp_valid, mem_cmd_en, acc_done}, 0);
    rst_n = 1'b1;
    wait_cycles(1);
    check("R1 quiet after reset", {req_ready, rsp_valid, mem_cmd_en, acc_done} == 4'b1000,
          {req_ready, rsp_valid, mem_cmd_en, acc_done}, 4'b1000);

    // uncalibrated: requests queue, nothing issues, full FIFO refuses
    req_rate = 100; req_budget = 6;
    wait_cycles(20);
    check("R2 only REQ_DEPTH accepted", accepted == RQD, accepted, RQD);
    check("R2 req_ready low when full", req_ready == 1'b0, req_ready, 0);
    check("R3 no command before calibration", cmd_cnt == 0 && viol_uncal == 0, cmd_cnt, 0);
    req_budget = 0;
    wait_cycles(2);

    mem_calib_done = 1'b1;
    rsp_rate = 100;
    drain();
    check("R2 refused offers never answered", rsp_cnt == RQD, rsp_cnt, RQD);

    // directed latency from acceptance to command
    rdy_force = 1;
    wait_cycles(5);
    req_budget = 1;
    drain();
    check("R10 command latency", first_en_cyc - last_acc_cyc == 3, first_en_cyc - last_acc_cyc, 3);
    rdy_force = 0;

    // random traffic
    for (int phase = 0; phase < 4; phase++) begin
      req_rate = 30 + phase * 20;
      rsp_rate = 90 - phase * 20;
      req_budget = 40;
      drain();
    end

    // response FIFO full: stall without dropping
    rsp_rate = 0;
    wait_cycles(2);
    base = done_cnt;
    req_rate = 100; req_budget = 10;
    wait_cycles(120);
    check("R8 stall at full response FIFO", done_cnt - base == RSD, done_cnt - base, RSD);
    check("R8 response held", rsp_valid == 1'b1, rsp_valid, 1);
    rsp_rate = 100;
    drain();

    // calibration dropping during traffic
    req_rate = 60; rsp_rate = 70; req_budget = 50;
    for (int k = 0; k < 12; k++) begin
      wait_cycles(5 + int'($urandom % 20));
      mem_calib_done = 1'b0;
      wait_cycles(1 + int'($urandom % 8));
      mem_calib_done = 1'b1;
    end
    drain();

    wait_cycles(10);
    check("R3 no command while uncalibrated", viol_uncal == 0, viol_uncal, 0);
    check("R4 enable held until ready", viol_hold == 0, viol_hold, 0);
    check("R4 one command per request", cmd_cnt == accepted, cmd_cnt, accepted);
    check("R7 done count matches responses", done_cnt == rsp_cnt, done_cnt, rsp_cnt);
    check("R7 done strobe single cycle", viol_done2 == 0, viol_done2, 0);
    check("R9 single outstanding access", viol_outst == 0, viol_outst, 0);
    finish_run();
  end
endmodule